// File: doc/BRIEF.md
# I2C Clock-Stretch Wait Release Controller

This block owns the clock-stretch wait of an I2C serial interface. When the shift engine reports the falling SCL edge that follows the ninth clock of a byte, the block enters a wait and drives SCL low. SCL stays low until software ends the wait through a register action. There are four such actions, and the one accepted picks what the engine does next: send a byte (data or address), receive the next byte or finish, issue a repeated start, or issue a stop.

The bit-level shift engine and address matching sit outside the block. They appear here only as an event input and as the action code and byte that the block hands back. A wakeup-mode level freezes the wait. A bus-release strobe lets go of both bus lines so that a bus locked up by noise can recover. Clearing the enable level aborts everything.

Top module: `i2c_wait_release`

## Requirements
- R1: When `ev_ninth_fall` is high while enabled, not waiting and not in bus-free state, `wait_pending` and `scl_hold` are high from the next cycle.
- R2: A data-register write during a wait ends it. `act_code` becomes 0 (transmit) and `tx_byte` takes the written byte. `sda_low` becomes the inverse of bit 7 of that byte.
- R3: A wait-release write during a wait ends it with `act_code` 1 (receive or finish) and `sda_low` 0.
- R4: A start request during a wait ends it with `act_code` 2 (repeated start) and `sda_low` 0, but only when `master` is 1. Otherwise the start request is ignored.
- R5: A stop request during a wait ends it with `act_code` 3 (stop) and `sda_low` 1, but only when `master` is 1. Otherwise the stop request is ignored.
- R6: When several valid actions arrive in the same cycle, the priority is stop, then start, then data write, then wait-release. Only the winner sets `act_code`.
- R7: Only one action is accepted per wait. Actions that arrive outside a wait leave `sda_low`, `act_code` and `tx_byte` unchanged, and they raise no `act_valid`.
- R8: While `wake_mode` is 1, every release action is ignored and the wait remains.
- R9: A bus-release strobe drops any wait and drives `scl_hold` and `sda_low` to 0. No new wait starts until a start request is seen.
- R10: While `en` is 0 there is no wait, `sda_low` is 0 and `act_valid` is 0. The bus-free state and `act_code` are also cleared.
- R11: `act_valid` pulses high for exactly one cycle, in the cycle after an action is accepted, and `wait_pending` falls at the same moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Interface enable level |
| master | input | 1 | 1 = master mode |
| wake_mode | input | 1 | 1 = release actions blocked |
| ev_ninth_fall | input | 1 | SCL fall after ninth clock (from shift engine) |
| wr_data | input | 1 | Data shift register write strobe |
| wr_byte | input | 8 | Byte written with `wr_data` |
| set_release | input | 1 | Wait-release bit write strobe |
| set_start | input | 1 | Start-request bit write strobe |
| set_stop | input | 1 | Stop-request bit write strobe |
| set_busrel | input | 1 | Bus-release bit write strobe |
| scl_hold | output | 1 | Drive SCL low |
| sda_low | output | 1 | Drive SDA low |
| wait_pending | output | 1 | Wait in force |
| act_valid | output | 1 | One-cycle pulse: action accepted |
| act_code | output | 2 | 0 transmit, 1 receive/finish, 2 restart, 3 stop |
| tx_byte | output | 8 | Byte to transmit |

## Verification
Three rules are checked by assertions on every cycle: a wait entry is never missed, a wait is not dropped while wake mode is on, and nothing changes between waits. They also check that a disable or a bus release clears the outputs, and that `act_valid` lasts only a single cycle. Priority among simultaneous actions, the gating of start and stop by master mode, the value of `tx_byte`, and the rule that a start request is needed to leave bus-free state depend on what was driven. A bench model that predicts every output on every cycle checks these in directed scenarios.

// File: rtl/i2c_wait_release.sv
module i2c_wait_release #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master,
  input  logic              wake_mode,
  input  logic              ev_ninth_fall,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              set_release,
  input  logic              set_start,
  input  logic              set_stop,
  input  logic              set_busrel,
  output logic              scl_hold,
  output logic              sda_low,
  output logic              wait_pending,
  output logic              act_valid,
  output logic [1:0]        act_code,
  output logic [BYTE_W-1:0] tx_byte
);
  localparam logic [1:0] ACT_TX = 2'd0, ACT_RX = 2'd1, ACT_RS = 2'd2, ACT_SP = 2'd3;

  logic waiting, freed;
  logic stop_ok, start_ok, any_ok, accept;
  logic [1:0] winner;

  assign stop_ok  = set_stop & master;
  assign start_ok = set_start & master;
  assign any_ok   = stop_ok | start_ok | wr_data | set_release;
  assign accept   = en & ~set_busrel & waiting & ~wake_mode & any_ok;
  assign winner   = stop_ok ? ACT_SP : start_ok ? ACT_RS : wr_data ? ACT_TX : ACT_RX;

  assign scl_hold     = waiting;
  assign wait_pending = waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      freed     <= 1'b0;
      sda_low   <= 1'b0;
      act_valid <= 1'b0;
      act_code  <= ACT_RX;
      tx_byte   <= '0;
    end else if (!en) begin
      waiting   <= 1'b0;
      freed     <= 1'b0;
      sda_low   <= 1'b0;
      act_valid <= 1'b0;
      act_code  <= ACT_RX;
    end else if (set_busrel) begin
      waiting   <= 1'b0;
      freed     <= 1'b1;
      sda_low   <= 1'b0;
      act_valid <= 1'b0;
    end else begin
      act_valid <= accept;
      if (accept) begin
        waiting  <= 1'b0;
        act_code <= winner;
        case (winner)
          ACT_TX: begin
            tx_byte <= wr_byte;
            sda_low <= ~wr_byte[BYTE_W-1];
          end
          ACT_SP:  sda_low <= 1'b1;
          default: sda_low <= 1'b0;
        endcase
      end else if (!waiting) begin
        if (freed) begin
          if (set_start) freed <= 1'b0;
        end else if (ev_ninth_fall) begin
          waiting <= 1'b1;
        end
      end
    end
  end

  a_r1_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !set_busrel && !waiting && !freed && ev_ninth_fall) |=> (wait_pending && scl_hold));
  a_r8_wake_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !set_busrel && waiting && wake_mode) |=> wait_pending);
  a_r7_no_change_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !set_busrel && !waiting) |=> ($stable(sda_low) && $stable(act_code) && $stable(tx_byte) && !act_valid));
  a_r9_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set_busrel) |=> (!scl_hold && !sda_low && !wait_pending));
  a_r10_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!wait_pending && !sda_low && !act_valid));
  a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> !act_valid);
  a_r11_fall_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> (!wait_pending && $past(wait_pending)));
endmodule

// File: tb/i2c_wait_release_tb.sv
module i2c_wait_release_tb_top;
  logic clk = 0, rst_n = 0;
  logic en = 0, master = 0, wake_mode = 0, ev_ninth_fall = 0;
  logic wr_data = 0, set_release = 0, set_start = 0, set_stop = 0, set_busrel = 0;
  logic [7:0] wr_byte = 0;
  logic scl_hold, sda_low, wait_pending, act_valid;
  logic [1:0] act_code;
  logic [7:0] tx_byte;

  always #4 clk = ~clk;

  i2c_wait_release dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit m_wait = 0, m_free = 0, m_sda = 0, m_av = 0;
  int m_act = 1;
  bit [7:0] m_byte = 0;

  task automatic check(string tag);
    n_chk++;
    if (scl_hold !== m_wait || wait_pending !== m_wait || sda_low !== m_sda ||
        act_valid !== m_av || act_code !== m_act[1:0] || tx_byte !== m_byte) begin
      n_bad++;
      $display("FAIL %s: got hold=%0b wp=%0b sda=%0b av=%0b act=%0d byte=%h exp hold=%0b sda=%0b av=%0b act=%0d byte=%h",
        tag, scl_hold, wait_pending, sda_low, act_valid, act_code, tx_byte,
        m_wait, m_sda, m_av, m_act, m_byte);
    end
  endtask

  task automatic model();
    bit st, sp;
    st = set_start && master;
    sp = set_stop && master;
    m_av = 0;
    if (!en) begin
      m_wait = 0; m_free = 0; m_sda = 0; m_act = 1;
    end else if (set_busrel) begin
      m_wait = 0; m_free = 1; m_sda = 0;
    end else if (m_wait && !wake_mode && (sp || st || wr_data || set_release)) begin
      m_wait = 0; m_av = 1;
      if (sp) begin m_act = 3; m_sda = 1; end
      else if (st) begin m_act = 2; m_sda = 0; end
      else if (wr_data) begin m_act = 0; m_byte = wr_byte; m_sda = !wr_byte[7]; end
      else begin m_act = 1; m_sda = 0; end
    end else if (!m_wait) begin
      if (m_free) begin if (set_start) m_free = 0; end
      else if (ev_ninth_fall) m_wait = 1;
    end
  endtask

  task automatic step(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    check(tag);
    ev_ninth_fall = 0; wr_data = 0; set_release = 0; set_start = 0; set_stop = 0; set_busrel = 0;
  endtask

  task automatic enter(string tag);
    ev_ninth_fall = 1; step(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset");
    rst_n = 1; en = 1; master = 1;
    step("R10 idle");
    enter("R1 enter");
    step("R1 hold");
    wr_data = 1; wr_byte = 8'h5A; step("R2 tx low bit7");
    step("R11 pulse ends");
    enter("R1 enter2");
    wr_data = 1; wr_byte = 8'hA3; step("R2 tx high bit7");
    set_release = 1; step("R7 late release ignored");
    wr_data = 1; wr_byte = 8'h11; step("R7 late write ignored");
    enter("R1");
    set_release = 1; step("R3 release");
    enter("R1");
    set_start = 1; step("R4 restart");
    enter("R1");
    set_stop = 1; step("R5 stop");
    master = 0;
    enter("R1");
    set_start = 1; step("R4 slave start ignored");
    set_stop = 1; step("R5 slave stop ignored");
    set_stop = 1; set_release = 1; step("R5 slave stop falls to release");
    master = 1;
    enter("R1");
    set_stop = 1; set_start = 1; wr_data = 1; set_release = 1; wr_byte = 8'h0F; step("R6 stop wins");
    enter("R1");
    set_start = 1; wr_data = 1; set_release = 1; wr_byte = 8'h0F; step("R6 start wins");
    enter("R1");
    wr_data = 1; set_release = 1; wr_byte = 8'hC4; step("R6 data wins");
    enter("R1");
    wake_mode = 1;
    set_release = 1; step("R8 release blocked");
    wr_data = 1; wr_byte = 8'h77; step("R8 write blocked");
    set_stop = 1; step("R8 stop blocked");
    wake_mode = 0;
    set_release = 1; step("R8 release after wake");
    enter("R1");
    set_busrel = 1; step("R9 bus release");
    ev_ninth_fall = 1; step("R9 no entry when free");
    set_start = 1; step("R9 start leaves free");
    enter("R9 entry resumes");
    en = 0; step("R10 disable clears");
    ev_ninth_fall = 1; step("R10 disabled no entry");
    en = 1;
    enter("R1 after enable");
    for (int i = 0; i < 20; i++) begin
      ev_ninth_fall = (i % 3 == 0);
      wr_data = (i % 4 == 1); wr_byte = 8'(i * 37);
      set_release = (i % 5 == 2);
      set_stop = (i % 7 == 3);
      step("R11 mixed");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule